// File: doc/BRIEF.md
# Locked Index/Data Configuration Port

This block gives a host access to a small configuration register space through two byte-wide I/O ports. One port holds a register index and the port just above it moves data to or from the indexed register. The base address comes from a strap input and is one of two fixed values.

The space starts out locked. While it is locked, data-port reads return all ones and data-port writes do nothing. To unlock it, the host writes an opening key twice in a row to the index port. A closing key written to the index port locks it again.

The global registers sit below index 0x30. They are a logical device number register and read-only identification bytes. Any index at or above 0x30 is passed through a side register port to the logical device that is currently selected. The host bus decoder and the devices behind the side port belong to other blocks.

Top module: `cfgport_ctl`

## Requirements
- R1: After reset the space is locked (`unlocked` low) and `dev_sel` is 0x00.
- R2: With `strap_alt` low the index port is at 0x2E and the data port at 0x2F. With it high they are at 0x4E and 0x4F. Key writes to the base that is not selected do not unlock the space.
- R3: Two index-port writes of 0x87 in a row, with no other index-port write between them, set `unlocked` high after the second write.
- R4: An index-port write of any value other than 0x87 between the two key writes restarts the sequence. After 0x87, 0x11, 0x87 the space stays locked, and one more 0x87 then unlocks it.
- R5: An index-port write of 0xAA while unlocked locks the space, and data-port reads return 0xFF again.
- R6: While locked, data-port reads return 0xFF. Data-port writes change no register and raise no `ld_stb`.
- R7: Index 0x07 is a read/write logical device number register. Its value is driven on `dev_sel` in the cycle after the write.
- R8: Reads at index 0x20 and 0x21 give the device ID high byte and then the low byte (default 0x13, 0x07). Index 0x22 gives the revision (default 0x02). Index 0x23 and 0x24 give 0x19 and 0x34. Other indices below 0x30 read 0x00, and writes to every global index except 0x07 are ignored.
- R9: When unlocked, a data-port access with index 0x30 or above raises `ld_stb` in that same cycle. `ld_addr` carries the index, `ld_we` is high for a write, `ld_wdata` carries the write byte, and a read returns `ld_rdata` on `io_rdata`.
- R10: `io_rdata` is 0xFF for index-port reads, for reads at any other address, and whenever no data-port read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_alt | input | 1 | Base select: 0 gives 0x2E, 1 gives 0x4E |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte, combinational |
| unlocked | output | 1 | Configuration space is open |
| dev_sel | output | 8 | Selected logical device number |
| ld_stb | output | 1 | Side-port access strobe |
| ld_we | output | 1 | Side-port write enable |
| ld_addr | output | 8 | Side-port register index |
| ld_wdata | output | 8 | Side-port write byte |
| ld_rdata | input | 8 | Side-port read byte from the selected device |

## Verification
The assertions take for granted that the host never raises `io_rd` and `io_wr` in the same cycle. They also assume that `strap_alt` is static while a key sequence is in progress, since the key properties recompute the decoded port address from it. The stimulus drives one access at a time, always holds one strobe low, and changes the strap only while the space is locked and between sequences. The side device is modelled as a fixed function of `ld_addr` and `dev_sel`, so that the read value forwarded through the data port can be predicted.

// File: rtl/cfgport_ctl.sv
module cfgport_ctl #(
  parameter logic [15:0] BASE_LO   = 16'h002E,
  parameter logic [15:0] BASE_HI   = 16'h004E,
  parameter logic [15:0] DEV_ID    = 16'h1307,
  parameter logic [15:0] MFG_ID    = 16'h1934,
  parameter logic [7:0]  REV_ID    = 8'h02,
  parameter logic [7:0]  KEY_OPEN  = 8'h87,
  parameter logic [7:0]  KEY_CLOSE = 8'hAA,
  parameter logic [7:0]  LDN_IDX   = 8'h07,
  parameter logic [7:0]  FWD_FLOOR = 8'h30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_alt,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        unlocked,
  output logic [7:0]  dev_sel,
  output logic        ld_stb,
  output logic        ld_we,
  output logic [7:0]  ld_addr,
  output logic [7:0]  ld_wdata,
  input  logic [7:0]  ld_rdata
);
  logic [15:0] base;
  logic        hit_idx, hit_dat, fwd;
  logic        open_q, half_q;
  logic [7:0]  idx_q, ldn_q, glb;

  assign base    = strap_alt ? BASE_HI : BASE_LO;
  assign hit_idx = (io_addr == base);
  assign hit_dat = (io_addr == base + 16'd1);
  assign fwd     = (idx_q >= FWD_FLOOR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      half_q <= 1'b0;
      idx_q  <= 8'h00;
      ldn_q  <= 8'h00;
    end else if (io_wr && hit_idx) begin
      if (!open_q) begin
        if (io_wdata == KEY_OPEN) begin
          open_q <= half_q;
          half_q <= ~half_q;
        end else begin
          half_q <= 1'b0;
        end
      end else if (io_wdata == KEY_CLOSE) begin
        open_q <= 1'b0;
        half_q <= 1'b0;
      end else begin
        idx_q <= io_wdata;
      end
    end else if (io_wr && hit_dat && open_q && idx_q == LDN_IDX) begin
      ldn_q <= io_wdata;
    end
  end

  always_comb begin
    case (idx_q)
      LDN_IDX: glb = ldn_q;
      8'h20:   glb = DEV_ID[15:8];
      8'h21:   glb = DEV_ID[7:0];
      8'h22:   glb = REV_ID;
      8'h23:   glb = MFG_ID[15:8];
      8'h24:   glb = MFG_ID[7:0];
      default: glb = 8'h00;
    endcase
  end

  assign io_rdata = (open_q && hit_dat && io_rd) ? (fwd ? ld_rdata : glb) : 8'hFF;
  assign ld_stb   = open_q & hit_dat & (io_rd | io_wr) & fwd;
  assign ld_we    = io_wr;
  assign ld_addr  = idx_q;
  assign ld_wdata = io_wdata;
  assign unlocked = open_q;
  assign dev_sel  = ldn_q;
endmodule

// File: rtl/cfgport_ctl_chk.sv
module cfgport_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        strap_alt,
  input logic [15:0] io_addr,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic        unlocked,
  input logic [7:0]  dev_sel,
  input logic        ld_stb,
  input logic [7:0]  ld_addr
);
  logic [15:0] ip;
  assign ip = strap_alt ? 16'h004E : 16'h002E;

  p_open_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(io_wr && io_addr == ip && io_wdata == 8'h87));

  p_close_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && io_wr && io_addr == ip && io_wdata == 8'hAA) |=> !unlocked);

  p_locked_reads_ff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_rd) |-> io_rdata == 8'hFF);

  p_locked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !ld_stb);

  p_ldn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(unlocked && io_wr && io_addr == ip + 16'd1) |=> $stable(dev_sel));

  p_fwd_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |-> (ld_addr >= 8'h30 && (io_rd || io_wr)));

  p_idle_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'hFF);
endmodule

bind cfgport_ctl cfgport_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
  .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .unlocked(unlocked), .dev_sel(dev_sel), .ld_stb(ld_stb), .ld_addr(ld_addr)
);

// File: tb/sim_cfgport_ctl.sv
module sim_cfgport_ctl;
  logic        clk = 1'b0, rst_n = 1'b0, strap_alt = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata, dev_sel, ld_addr, ld_wdata, ld_rdata;
  logic        unlocked, ld_stb, ld_we;
  int          n_chk = 0, n_bad = 0, n_stb = 0;
  logic [7:0]  cap_a = 8'h0, cap_d = 8'h0;

  always #5 clk = ~clk;

  cfgport_ctl u0 (.*);

  assign ld_rdata = {ld_addr[3:0], dev_sel[3:0]};

  always @(posedge clk) if (ld_stb) begin
    n_stb <= n_stb + 1;
    if (ld_we) begin cap_a <= ld_addr; cap_d <= ld_wdata; end
  end

  // op(1=read) port(1=data) data exp
  localparam logic [17:0] TBL [17] = '{
    {1'b0,1'b0,8'h87,8'h00}, {1'b0,1'b0,8'h87,8'h00},
    {1'b0,1'b0,8'h20,8'h00}, {1'b1,1'b1,8'h00,8'h13},
    {1'b0,1'b0,8'h21,8'h00}, {1'b1,1'b1,8'h00,8'h07},
    {1'b0,1'b0,8'h22,8'h00}, {1'b1,1'b1,8'h00,8'h02},
    {1'b0,1'b0,8'h23,8'h00}, {1'b1,1'b1,8'h00,8'h19},
    {1'b0,1'b0,8'h24,8'h00}, {1'b1,1'b1,8'h00,8'h34},
    {1'b0,1'b0,8'h07,8'h00}, {1'b0,1'b1,8'h06,8'h00},
    {1'b1,1'b1,8'h00,8'h06}, {1'b0,1'b0,8'h15,8'h00},
    {1'b1,1'b1,8'h00,8'h00}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic iow(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic ior(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 v = io_rdata;
    @(posedge clk); #1 io_rd = 1'b0;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 unlocked", {7'b0, unlocked}, 8'h00);
    chk("R1 dev_sel", dev_sel, 8'h00);

    ior(16'h002F, v); chk("R6 locked read", v, 8'hFF);
    s0 = n_stb;
    iow(16'h002F, 8'h55);
    chk("R6 locked write", dev_sel, 8'h00);
    chk("R6 no strobe", 8'(n_stb - s0), 8'h00);

    iow(16'h002E, 8'h87); iow(16'h002E, 8'h11); iow(16'h002E, 8'h87);
    chk("R4 broken key", {7'b0, unlocked}, 8'h00);
    iow(16'h002E, 8'h87);
    chk("R3 unlock", {7'b0, unlocked}, 8'h01);
    iow(16'h002E, 8'hAA);
    chk("R5 lock", {7'b0, unlocked}, 8'h00);

    iow(16'h004E, 8'h87); iow(16'h004E, 8'h87);
    chk("R2 wrong base", {7'b0, unlocked}, 8'h00);
    strap_alt = 1'b1;
    iow(16'h004E, 8'h87); iow(16'h004E, 8'h87);
    chk("R2 alt base", {7'b0, unlocked}, 8'h01);
    ior(16'h004E, v); chk("R10 index read", v, 8'hFF);
    ior(16'h0123, v); chk("R10 foreign read", v, 8'hFF);
    iow(16'h004E, 8'hAA);
    strap_alt = 1'b0;

    foreach (TBL[i]) begin
      if (TBL[i][17]) begin
        ior(TBL[i][16] ? 16'h002F : 16'h002E, v);
        chk($sformatf("R8/R7 table %0d", i), v, TBL[i][7:0]);
      end else begin
        iow(TBL[i][16] ? 16'h002F : 16'h002E, TBL[i][15:8]);
      end
    end
    chk("R7 dev_sel", dev_sel, 8'h06);

    iow(16'h002E, 8'h20); iow(16'h002F, 8'h00);
    ior(16'h002F, v); chk("R8 id write ignored", v, 8'h13);

    iow(16'h002E, 8'h35);
    ior(16'h002F, v); chk("R9 forwarded read", v, 8'h56);
    iow(16'h002F, 8'hC3);
    chk("R9 side addr", cap_a, 8'h35);
    chk("R9 side data", cap_d, 8'hC3);

    iow(16'h002E, 8'hAA);
    ior(16'h002F, v); chk("R5 read after lock", v, 8'hFF);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule